// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit memory-mapped host reach a small internal register space that has an 8-bit address and an 8-bit data path. The host does not address the internal registers directly. It loads a command word into a control register, and the bridge then runs a fixed-length transfer on a slow internal byte bus. While that transfer runs, a busy bit is set, and the host polls this bit before it issues anything else.

A read is launched by the command write itself when the command's direction bit asks for a read. When busy drops, the fetched byte sits in the lower data register. A write needs two host writes. First the host writes a command with the direction bit clear, then it writes the lower data register, and that data write launches the transfer.

The bridge also merges two interrupt sources into one host interrupt line. One source is rising edges on the internal space's interrupt wire. The other is host writes that the bridge drops because they arrived while busy was set. Each source has a sticky flag, the host clears a flag by writing 1 to it, and each flag has its own enable bit.

Top module: `ind_bridge`

## Requirements
- R1: After reset, word offset 0x00 reads the constant ID_VALUE (default 0x5A1B0001). Offsets 0x04, 0x08, 0x0C, 0x10 and 0x14 all read 0, and irq_o is low.
- R2: The control word at offset 0x04 holds the following fields:
  - bit 25: size;
  - bit 24: direction (1 = read);
  - bits 23:20: upper byte enables;
  - bits 19:16: lower byte enables;
  - bits 7:0: internal address.
  
  Bits 30:26 and 15:8 read as 0. Bit 31 reads the busy state, and writes to it are ignored.
- R3: A control write with bit 24 = 1, accepted while idle, starts a read. Busy then reads 1 for exactly 4 cycles. After that, lower data (0x08) holds the fetched byte in bits 7:0 with bits 31:8 zero.
- R4: A lower-data write, accepted while idle after a control word with bit 24 = 0, starts a write transfer. This transfer sends bits 7:0 of the written value to the internal address held in the control word, and busy reads 1 for 4 cycles.
- R5: Each transfer drives exactly one strobe cycle on ib_stb_o, in the second busy cycle. ib_we_o is 1 for a write transfer and 0 for a read transfer.
- R6: A host write to control, lower data or upper data while busy is set changes none of those registers. It also sets interrupt flag bit 0.
- R7: A rising edge on ib_irq_i sets interrupt flag bit 1 (offset 0x14). A level held high does not set the flag again after it has been cleared.
- R8: Flag bits clear when 1 is written to them at offset 0x14, and writing 0 leaves them unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: irq_o is the OR over both bits of (flag AND enable). The enable register is at offset 0x10 and uses the same bit positions as the flags.
- R10: The upper data register (0x0C) is plain storage. A lower-data write issued while the stored direction bit is 1 only updates the register and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access valid for one cycle |
| we_i | input | 1 | Host access is a write |
| addr_i | input | AW (5) | Host byte address, word aligned |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data for addr_i, combinational |
| irq_o | output | 1 | Host interrupt |
| ib_addr_o | output | 8 | Internal bus address |
| ib_wdata_o | output | 8 | Internal bus write byte |
| ib_we_o | output | 1 | Internal bus write direction |
| ib_stb_o | output | 1 | Internal bus strobe, one cycle per transfer |
| ib_rdata_i | input | 8 | Internal bus read byte |
| ib_irq_i | input | 1 | Interrupt level from the internal space |

## Verification
Two situations are the hardest to reach from the ports.

- **Dropped writes.** The bench issues a read command and then, with no gap, writes control, lower data and upper data. All three writes land inside the 4-cycle busy window. The bench then checks that the command, the captured byte and the upper word survive, and that the drop flag is set.
- **Set against clear.** The same flag must be set and cleared in one cycle. The bench raises ib_irq_i on the same clock edge that carries a write-one-to-clear of flag bit 1. The flag must then read back as set.

A scoreboard queue holds the expected read values and compares each one against rdata_o in the cycle of the host read.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  // word index of each host register (byte offset / 4)
  localparam logic [2:0] W_ID   = 3'd0;
  localparam logic [2:0] W_CTRL = 3'd1;
  localparam logic [2:0] W_LDAT = 3'd2;
  localparam logic [2:0] W_UDAT = 3'd3;
  localparam logic [2:0] W_IEN  = 3'd4;
  localparam logic [2:0] W_IFLG = 3'd5;

  localparam int unsigned B_BUSY = 31;
  localparam int unsigned B_DIR  = 24;
  localparam logic [31:0] CMD_MASK = 32'h03FF_00FF;

  localparam int unsigned IRQ_N = 2;
  localparam int unsigned I_BRG = 0;
  localparam int unsigned I_INT = 1;
endpackage

// File: rtl/ind_bridge_seq.sv
module ind_bridge_seq #(
  parameter int unsigned ACC_CYC = 4,
  parameter int unsigned STB_AT  = 1,
  parameter int unsigned AB      = 8,
  parameter int unsigned DB      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          st_we_i,
  input  logic [AB-1:0] st_addr_i,
  input  logic [DB-1:0] st_byte_i,
  output logic          busy_o,
  output logic          done_rd_o,
  output logic [DB-1:0] rd_byte_o,
  output logic [AB-1:0] ib_addr_o,
  output logic [DB-1:0] ib_wdata_o,
  output logic          ib_we_o,
  output logic          ib_stb_o,
  input  logic [DB-1:0] ib_rdata_i
);
  localparam int unsigned CW = (ACC_CYC > 2) ? $clog2(ACC_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] STB  = CW'(STB_AT);

  logic          busy_q, we_q;
  logic [CW-1:0] cnt_q;
  logic [AB-1:0] addr_q;
  logic [DB-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      byte_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        we_q   <= st_we_i;
        addr_q <= st_addr_i;
        byte_q <= st_byte_i;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign ib_stb_o   = busy_q && (cnt_q == STB);
  assign ib_we_o    = busy_q && we_q;
  assign ib_addr_o  = addr_q;
  assign ib_wdata_o = byte_q;
  assign done_rd_o  = busy_q && (cnt_q == LAST) && !we_q;
  assign rd_byte_o  = ib_rdata_i;

  // R5: one strobe per transfer, never in the first busy cycle
  a_r5_one_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_stb_o |=> !ib_stb_o);
  a_r5_stb_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_stb_o |-> $past(busy_q));
  // R3: busy ends only after the last access cycle
  a_r3_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == LAST);
  // R6: a transfer in flight keeps its target
  a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(addr_q));
endmodule

// File: rtl/ind_bridge_regs.sv
module ind_bridge_regs
  import ind_bridge_pkg::*;
#(
  parameter int unsigned AW       = 5,
  parameter logic [31:0] ID_VALUE = 32'h5A1B_0001,
  parameter int unsigned AB       = 8,
  parameter int unsigned DB       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             done_rd_i,
  input  logic [DB-1:0]    rd_byte_i,
  input  logic [IRQ_N-1:0] flag_i,
  output logic [IRQ_N-1:0] ien_o,
  output logic [IRQ_N-1:0] fclr_o,
  output logic             drop_o,
  output logic             start_o,
  output logic             st_we_o,
  output logic [AB-1:0]    st_addr_o,
  output logic [DB-1:0]    st_byte_o
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0]    widx;
  logic             wr, acc;
  logic             hit_ctrl, hit_ldat, hit_udat, hit_ien, hit_iflg;
  logic [31:0]      ctrl_q, ldat_q, udat_q;
  logic [IRQ_N-1:0] ien_q;

  assign widx     = addr_i[AW-1:2];
  assign hit_ctrl = (widx == IW'(W_CTRL));
  assign hit_ldat = (widx == IW'(W_LDAT));
  assign hit_udat = (widx == IW'(W_UDAT));
  assign hit_ien  = (widx == IW'(W_IEN));
  assign hit_iflg = (widx == IW'(W_IFLG));

  assign wr     = req_i && we_i;
  assign acc    = wr && !busy_i;
  assign drop_o = wr && busy_i && (hit_ctrl || hit_ldat || hit_udat);

  // read starts on the command, write starts on the data
  assign start_o   = acc && ((hit_ctrl && wdata_i[B_DIR]) ||
                             (hit_ldat && !ctrl_q[B_DIR]));
  assign st_we_o   = hit_ldat;
  assign st_addr_o = hit_ctrl ? wdata_i[AB-1:0] : ctrl_q[AB-1:0];
  assign st_byte_o = wdata_i[DB-1:0];
  assign fclr_o    = (wr && hit_iflg) ? wdata_i[IRQ_N-1:0] : '0;
  assign ien_o     = ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ldat_q <= '0;
      udat_q <= '0;
      ien_q  <= '0;
    end else begin
      if (acc && hit_ctrl) ctrl_q <= wdata_i & CMD_MASK;
      if (done_rd_i)             ldat_q <= {{(32-DB){1'b0}}, rd_byte_i};
      else if (acc && hit_ldat)  ldat_q <= wdata_i;
      if (acc && hit_udat) udat_q <= wdata_i;
      if (wr && hit_ien)   ien_q  <= wdata_i[IRQ_N-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (widx == IW'(W_ID))  rdata_o = ID_VALUE;
    else if (hit_ctrl)           rdata_o = ctrl_q | (32'(busy_i) << B_BUSY);
    else if (hit_ldat)           rdata_o = ldat_q;
    else if (hit_udat)           rdata_o = udat_q;
    else if (hit_ien)            rdata_o = {{(32-IRQ_N){1'b0}}, ien_q};
    else if (hit_iflg)           rdata_o = {{(32-IRQ_N){1'b0}}, flag_i};
  end

  // R6: command and upper word frozen during a transfer
  a_r6_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ctrl_q));
  a_r6_udat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(udat_q));
  // R2: unused control bits never become set
  a_r2_ctrl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CMD_MASK) == 32'h0);
endmodule

// File: rtl/ind_bridge_irq.sv
module ind_bridge_irq
  import ind_bridge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_i,
  input  logic             drop_i,
  input  logic [IRQ_N-1:0] clr_i,
  input  logic [IRQ_N-1:0] en_i,
  output logic [IRQ_N-1:0] flag_o,
  output logic             irq_o
);
  logic             prev_q;
  logic [IRQ_N-1:0] flag_q, set;

  always_comb begin
    set        = '0;
    set[I_BRG] = drop_i;
    set[I_INT] = ext_i && !prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= '0;
    end else begin
      prev_q <= ext_i;
      flag_q <= (flag_q & ~clr_i) | set;  // set wins over clear
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);

  // R7: edge on the internal line is recorded
  a_r7_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_i && !prev_q) |=> flag_q[I_INT]);
  // R6: dropped host write is recorded
  a_r6_drop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> flag_q[I_BRG]);
  // R8: flags are sticky until written with 1
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[I_BRG] && !clr_i[I_BRG]) |=> flag_q[I_BRG]);
endmodule

// File: rtl/ind_bridge.sv
module ind_bridge
  import ind_bridge_pkg::*;
#(
  parameter int unsigned AW       = 5,
  parameter logic [31:0] ID_VALUE = 32'h5A1B_0001,
  parameter int unsigned AB       = 8,
  parameter int unsigned DB       = 8,
  parameter int unsigned ACC_CYC  = 4,
  parameter int unsigned STB_AT   = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  output logic [AB-1:0] ib_addr_o,
  output logic [DB-1:0] ib_wdata_o,
  output logic          ib_we_o,
  output logic          ib_stb_o,
  input  logic [DB-1:0] ib_rdata_i,
  input  logic          ib_irq_i
);
  logic             busy, done_rd, drop, start, st_we;
  logic [DB-1:0]    rd_byte, st_byte;
  logic [AB-1:0]    st_addr;
  logic [IRQ_N-1:0] flag, ien, fclr;

  ind_bridge_regs #(.AW(AW), .ID_VALUE(ID_VALUE), .AB(AB), .DB(DB)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_rd_i(done_rd), .rd_byte_i(rd_byte),
    .flag_i(flag), .ien_o(ien), .fclr_o(fclr), .drop_o(drop),
    .start_o(start), .st_we_o(st_we), .st_addr_o(st_addr), .st_byte_o(st_byte)
  );

  ind_bridge_seq #(.ACC_CYC(ACC_CYC), .STB_AT(STB_AT), .AB(AB), .DB(DB)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .st_we_i(st_we), .st_addr_i(st_addr),
    .st_byte_i(st_byte), .busy_o(busy), .done_rd_o(done_rd), .rd_byte_o(rd_byte),
    .ib_addr_o, .ib_wdata_o, .ib_we_o, .ib_stb_o, .ib_rdata_i
  );

  ind_bridge_irq u_irq (
    .clk_i, .rst_ni, .ext_i(ib_irq_i), .drop_i(drop), .clr_i(fclr),
    .en_i(ien), .flag_o(flag), .irq_o
  );
endmodule

// File: tb/tb_ind_bridge.sv
`timescale 1ns/1ps
module tb_ind_bridge;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_o, ib_we_o, ib_stb_o;
  logic [7:0]  ib_addr_o, ib_wdata_o, ib_rdata_i;
  logic        ib_irq_i = 1'b0;

  int total = 0, bad = 0, stb_cnt = 0;
  bit done = 0;
  logic [7:0]  mem [256];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ind_bridge dut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o,
    .ib_addr_o, .ib_wdata_o, .ib_we_o, .ib_stb_o, .ib_rdata_i, .ib_irq_i
  );

  // internal register space model
  assign ib_rdata_i = mem[ib_addr_o];
  always @(posedge clk) if (ib_stb_o) begin
    stb_cnt <= stb_cnt + 1;
    if (ib_we_o) mem[ib_addr_o] <= ib_wdata_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each host read against the queued value
  always @(negedge clk) begin
    #1;
    if (req_i && !we_i && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata_o === e, t, rdata_o, e);
    end
  end

  // tasks are entered just after a falling edge
  task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic hread(input logic [4:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 50; k++) begin
      peek(5'h04, v);
      if (!v[31]) break;
      n++;
    end
  endtask

  initial begin
    int n, s0;
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    hread(5'h00, 32'h5A1B_0001, "R1 id");
    hread(5'h04, 32'h0, "R1 ctrl");
    hread(5'h08, 32'h0, "R1 ldat");
    hread(5'h0C, 32'h0, "R1 udat");
    hread(5'h10, 32'h0, "R1 ien");
    hread(5'h14, 32'h0, "R1 iflg");
    #1 chk(irq_o === 1'b0, "R1 irq", 32'(irq_o), 0);
    @(negedge clk);

    // R3 read transfer
    s0 = stb_cnt;
    hwrite(5'h04, 32'h0103_003C);
    #1 chk(ib_stb_o === 1'b0, "R5 no stb first cycle", 32'(ib_stb_o), 0);
    @(negedge clk);
    #1 chk(ib_stb_o === 1'b1 && ib_we_o === 1'b0 && ib_addr_o === 8'h3C,
           "R5 read strobe", {ib_stb_o, ib_we_o, ib_addr_o}, {2'b10, 8'h3C});
    wait_idle(n);
    chk(n == 3, "R3 busy cycles", n + 1, 4);
    chk(stb_cnt - s0 == 1, "R5 one strobe", stb_cnt - s0, 1);
    hread(5'h08, 32'h0000_0099, "R3 fetched byte");
    hread(5'h04, 32'h0103_003C, "R2 ctrl after read");

    // R2 field layout, dir 0 starts nothing
    s0 = stb_cnt;
    hwrite(5'h04, 32'hFEFF_FF12);
    hread(5'h04, 32'h02FF_0012, "R2 field mask");
    chk(stb_cnt == s0, "R2 no transfer", stb_cnt - s0, 0);

    // R4 write transfer
    hwrite(5'h04, 32'h0001_0050);
    s0 = stb_cnt;
    hwrite(5'h08, 32'h1234_56C7);
    wait_idle(n);
    chk(n == 4, "R4 busy cycles", n, 4);
    chk(mem[8'h50] === 8'hC7, "R4 byte written", 32'(mem[8'h50]), 32'hC7);
    chk(stb_cnt - s0 == 1, "R5 write one strobe", stb_cnt - s0, 1);
    hwrite(5'h04, 32'h0101_0050);
    wait_idle(n);
    hread(5'h08, 32'h0000_00C7, "R4 readback");

    // R10 upper data and data write in read mode
    hwrite(5'h0C, 32'hDEAD_BEEF);
    hread(5'h0C, 32'hDEAD_BEEF, "R10 udat");
    s0 = stb_cnt;
    hwrite(5'h08, 32'h0000_0077);
    peek(5'h04, v);
    chk(v[31] === 1'b0 && stb_cnt == s0, "R10 no transfer", {v[31], 31'(stb_cnt - s0)}, 0);
    hread(5'h08, 32'h0000_0077, "R10 ldat stored");
    hread(5'h14, 32'h0, "R6 no drop yet");

    // R6 writes dropped while busy
    hwrite(5'h04, 32'h0100_0010);
    hwrite(5'h04, 32'h0100_0020);
    hwrite(5'h08, 32'h0000_00AB);
    hwrite(5'h0C, 32'h0000_0011);
    wait_idle(n);
    hread(5'h04, 32'h0100_0010, "R6 ctrl kept");
    hread(5'h08, 32'h0000_00B5, "R6 ldat kept");
    hread(5'h0C, 32'hDEAD_BEEF, "R6 udat kept");
    hread(5'h14, 32'h1, "R6 drop flag");

    // R9 enable gating
    #1 chk(irq_o === 1'b0, "R9 masked", 32'(irq_o), 0);
    @(negedge clk);
    hwrite(5'h10, 32'h1);
    #1 chk(irq_o === 1'b1, "R9 enabled", 32'(irq_o), 1);
    @(negedge clk);

    // R8 write-one-to-clear
    hwrite(5'h14, 32'h0);
    hread(5'h14, 32'h1, "R8 zero no effect");
    hwrite(5'h14, 32'h1);
    hread(5'h14, 32'h0, "R8 cleared");
    #1 chk(irq_o === 1'b0, "R9 low after clear", 32'(irq_o), 0);
    @(negedge clk);

    // R7 edge detection
    hwrite(5'h10, 32'h2);
    ib_irq_i = 1'b1;
    @(negedge clk);
    hread(5'h14, 32'h2, "R7 edge sets");
    #1 chk(irq_o === 1'b1, "R9 internal irq", 32'(irq_o), 1);
    @(negedge clk);
    hwrite(5'h14, 32'h2);
    repeat (3) @(negedge clk);
    hread(5'h14, 32'h0, "R7 level no reset");

    // R8 set wins over clear in the same cycle
    ib_irq_i = 1'b0;
    @(negedge clk);
    ib_irq_i = 1'b1;
    hwrite(5'h14, 32'h2);
    hread(5'h14, 32'h2, "R8 set wins");

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule